// File: doc/BRIEF.md
# LED Enable Synchronizer with Aggregate Current Limit

This block decides, for three LED channels (red, green, blue), whether each channel's current sink may draw current and at what level. Each channel has an external enable pin and a 3-bit current code. A code `c` asks for `c + 1` units of 8.4 mA, so the range runs from 8.4 mA to 67.2 mA in steps of one eighth of full scale. The analog sinks sit outside this block. They take the per-channel drive flag and level code from this block's outputs.

The enable pins take effect only on a falling edge of the sampling pulse. The block samples that pulse on its own clock. On the clock edge where the pulse is low after being high, it latches the enable pins. On the same edge it adds up the weights of the channels that are now enabled. If that sum exceeds the budget of 12 units (150% of one channel's full scale, 100.8 mA), every channel is held off until the next falling edge. Capping the current at the budget is not an option this block offers. A global power control forces all drive flags low at once. If the sampling pulse stops, changes on the enable pins have no effect.

Top module: `ledg_top`

## Requirements
- R1: Asserting `lvl_we[i]` loads `lvl_wdata[3i+2:3i]` into channel i's code register. The code appears on `drv_lvl[3i+2:3i]` from the next cycle. A code c weighs c+1 units of 8.4 mA.
- R2: `en_in` is latched only on a clock edge where `samp` is low and was high at the previous edge. `drv_on` shows the latched value from that edge onward. Changes on `en_in` at any other time have no effect on `drv_on`.
- R3: If the sum of (code+1) over the newly latched enabled channels exceeds 12 units, all bits of `drv_on` are 0 until the next falling edge. The codes used are those held before that edge.
- R4: A sum of exactly 12 units is within budget, and every enabled channel drives.
- R5: Within budget, `drv_on[i]` equals the latched enable of channel i, independent of the other channels. Bit 0 is red, bit 1 is green and bit 2 is blue.
- R6: While `pwr_on` is low, `drv_on` is all zero in the same cycle. The latched state is kept, so raising `pwr_on` restores the previous flags.
- R7: A code write between falling edges does not change `drv_on`. The new code enters the budget check at the next falling edge.
- R8: After reset, `drv_on` and `drv_lvl` are all zero, and the latched enables are clear. The enable pins are expected to be low when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp | input | 1 | Sampling pulse, synchronous to clk; its falling edge latches enables |
| en_in | input | 3 | Per-channel enable pins, bit i = channel i |
| pwr_on | input | 1 | 1 = normal operation, 0 = all drives forced off |
| lvl_we | input | 3 | Per-channel code write strobe |
| lvl_wdata | input | 9 | Codes to write, channel i at bits [3i+2:3i] |
| drv_on | output | 3 | Per-channel drive flag |
| drv_lvl | output | 9 | Per-channel current code, channel i at bits [3i+2:3i] |

## Verification
Each code write appears on `drv_lvl` one cycle after its strobe. A falling edge of `samp` is seen on the first clock edge at which `samp` is low after a high sample. `drv_on` reflects that edge immediately after it. Power control acts within the same cycle. The bench drives every input at the falling clock edge. It lets a pulse rise for one full cycle and fall for one, and reads the outputs at the next falling clock edge. By then the single latching edge has passed and no further one can have occurred. Budget cases sit on both sides of 12 units. Writes placed between pulses check that codes enter the check only at the next pulse.

// File: rtl/ledg_pkg.sv
package ledg_pkg;

   typedef enum logic [0:0] {
      LIM_BLOCK_ALL = 1'b0,
      LIM_NONE      = 1'b1
   } lim_mode_e;

   function automatic int unsigned unit_weight(input int unsigned code);
      return code + 1;
   endfunction

endpackage

// File: rtl/ledg_edge.sv
module ledg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic samp,
   output logic fall
);
   logic samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_q <= 1'b0;
      else        samp_q <= samp;
   end

   assign fall = samp_q & ~samp;
endmodule

// File: rtl/ledg_codes.sv
module ledg_codes #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CODE_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        we,
   input  logic [NUM_CH*CODE_W-1:0] wdata,
   output logic [NUM_CH*CODE_W-1:0] codes
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     code_q <= '0;
         else if (we[i]) code_q <= wdata[i*CODE_W +: CODE_W];
      end
      assign codes[i*CODE_W +: CODE_W] = code_q;
   end
endmodule

// File: rtl/ledg_budget.sv
module ledg_budget
   import ledg_pkg::*;
#(
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned BUDGET   = 12,
   parameter lim_mode_e   LIM_MODE = LIM_BLOCK_ALL
) (
   input  logic [NUM_CH-1:0]        en,
   input  logic [NUM_CH*CODE_W-1:0] codes,
   output logic                     over
);
   localparam int unsigned MAX_SUM = NUM_CH * (1 << CODE_W);
   localparam int unsigned SUM_W   = $clog2(MAX_SUM + 1);

   if (LIM_MODE == LIM_BLOCK_ALL) begin : g_limit
      logic [SUM_W-1:0] sum;
      always_comb begin
         sum = '0;
         for (int i = 0; i < NUM_CH; i++) begin
            if (en[i])
               sum = sum + SUM_W'(codes[i*CODE_W +: CODE_W]) + SUM_W'(1);
         end
      end
      assign over = (32'(sum) > BUDGET);
   end else begin : g_nolimit
      logic unused;
      assign unused = ^{en, codes};
      assign over   = 1'b0;
   end
endmodule

// File: rtl/ledg_top.sv
module ledg_top
   import ledg_pkg::*;
#(
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned BUDGET   = 12,
   parameter lim_mode_e   LIM_MODE = LIM_BLOCK_ALL
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     samp,
   input  logic [NUM_CH-1:0]        en_in,
   input  logic                     pwr_on,
   input  logic [NUM_CH-1:0]        lvl_we,
   input  logic [NUM_CH*CODE_W-1:0] lvl_wdata,
   output logic [NUM_CH-1:0]        drv_on,
   output logic [NUM_CH*CODE_W-1:0] drv_lvl
);
   localparam int unsigned MAX_SUM = NUM_CH * (1 << CODE_W);

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_ch
      $error("ledg_top: NUM_CH out of range");
   end
   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_w
      $error("ledg_top: CODE_W out of range");
   end
   if (BUDGET < 1 || BUDGET > MAX_SUM) begin : g_bad_budget
      $error("ledg_top: BUDGET must lie within 1..NUM_CH*2**CODE_W");
   end

   logic                     fall;
   logic                     over_now;
   logic [NUM_CH-1:0]        en_q;
   logic                     over_q;
   logic [NUM_CH*CODE_W-1:0] codes;

   ledg_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .samp  (samp),
      .fall  (fall)
   );

   ledg_codes #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_codes (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lvl_we),
      .wdata (lvl_wdata),
      .codes (codes)
   );

   ledg_budget #(
      .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUDGET(BUDGET), .LIM_MODE(LIM_MODE)
   ) u_budget (
      .en    (en_in),
      .codes (codes),
      .over  (over_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         over_q <= 1'b0;
      end else if (fall) begin
         en_q   <= en_in;
         over_q <= over_now;
      end
   end

   assign drv_on  = pwr_on ? (en_q & {NUM_CH{~over_q}}) : '0;
   assign drv_lvl = codes;
endmodule

// File: rtl/ledg_chk.sv
module ledg_chk
   import ledg_pkg::*;
#(
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned BUDGET   = 12,
   parameter lim_mode_e   LIM_MODE = LIM_BLOCK_ALL
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     samp,
   input logic [NUM_CH-1:0]        en_in,
   input logic                     pwr_on,
   input logic [NUM_CH-1:0]        lvl_we,
   input logic [NUM_CH*CODE_W-1:0] lvl_wdata,
   input logic [NUM_CH-1:0]        drv_on,
   input logic [NUM_CH*CODE_W-1:0] drv_lvl,
   input logic [NUM_CH-1:0]        en_q,
   input logic                     over_q
);
   logic s_prev;
   logic fall_c;
   int unsigned wsum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= samp;
   end
   assign fall_c = s_prev & ~samp;

   always_comb begin
      wsum = 0;
      for (int i = 0; i < NUM_CH; i++)
         if (en_in[i]) wsum = wsum + unit_weight(32'(drv_lvl[i*CODE_W +: CODE_W]));
   end

   p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_c |=> en_q == $past(en_in));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_c |=> $stable(en_q) && $stable(over_q));

   p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && LIM_MODE == LIM_BLOCK_ALL) |=> over_q == ($past(wsum) > BUDGET));

   p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |-> drv_on == '0);

   p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && !over_q) |-> drv_on == en_q);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lvl
      p_lvl_r1: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_we[i] |=> drv_lvl[i*CODE_W +: CODE_W] == $past(lvl_wdata[i*CODE_W +: CODE_W]));
   end
endmodule

bind ledg_top ledg_chk #(
   .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUDGET(BUDGET), .LIM_MODE(LIM_MODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp      (samp),
   .en_in     (en_in),
   .pwr_on    (pwr_on),
   .lvl_we    (lvl_we),
   .lvl_wdata (lvl_wdata),
   .drv_on    (drv_on),
   .drv_lvl   (drv_lvl),
   .en_q      (en_q),
   .over_q    (over_q)
);

// File: tb/ledg_top_test.sv
module ledg_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp = 1'b0;
   logic [2:0] en_in = '0;
   logic       pwr_on = 1'b1;
   logic [2:0] lvl_we = '0;
   logic [8:0] lvl_wdata = '0;
   logic [2:0] drv_on;
   logic [8:0] drv_lvl;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [2:0] m_code [3];
   logic [2:0] m_en;
   logic       m_over;

   always #5 clk = ~clk;

   ledg_top uut (
      .clk(clk), .rst_n(rst_n), .samp(samp), .en_in(en_in), .pwr_on(pwr_on),
      .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .drv_on(drv_on), .drv_lvl(drv_lvl)
   );

   function automatic bit over_of(input logic [2:0] en);
      int s = 0;
      for (int i = 0; i < 3; i++) if (en[i]) s += int'(m_code[i]) + 1;
      return s > 12;
   endfunction

   function automatic logic [2:0] exp_on();
      if (!pwr_on) return 3'b000;
      return m_over ? 3'b000 : m_en;
   endfunction

   function automatic logic [8:0] exp_lvl();
      return {m_code[2], m_code[1], m_code[0]};
   endfunction

   task automatic check(input logic [8:0] got, input logic [8:0] exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] mask, input logic [2:0] c0,
                     input logic [2:0] c1, input logic [2:0] c2);
      @(negedge clk);
      lvl_we = mask;
      lvl_wdata = {c2, c1, c0};
      @(negedge clk);
      lvl_we = '0;
      if (mask[0]) m_code[0] = c0;
      if (mask[1]) m_code[1] = c1;
      if (mask[2]) m_code[2] = c2;
   endtask

   task automatic pulse();
      @(negedge clk);
      samp = 1'b1;
      @(negedge clk);
      samp = 1'b0;
      m_en = en_in;
      m_over = over_of(en_in);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1ed5));
      for (int i = 0; i < 3; i++) m_code[i] = '0;
      m_en = '0;
      m_over = 1'b0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check({6'd0, drv_on}, 9'd0, "R8 drv_on in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check({6'd0, drv_on}, 9'd0, "R8 drv_on after reset");
      check(drv_lvl, 9'd0, "R8 codes after reset");

      // R1: code writes
      wr(3'b111, 3'd2, 3'd5, 3'd7);
      check(drv_lvl, exp_lvl(), "R1 code write all");
      wr(3'b010, 3'd0, 3'd1, 3'd0);
      check(drv_lvl, exp_lvl(), "R1 code write single");

      // R2: enables ignored without a falling edge
      en_in = 3'b001;
      repeat (5) @(negedge clk);
      check({6'd0, drv_on}, 9'd0, "R2 no pulse no effect");
      pulse();
      check({6'd0, drv_on}, {6'd0, exp_on()}, "R2 enable on pulse");
      en_in = 3'b110;
      samp = 1'b1;
      repeat (4) @(negedge clk);
      check({6'd0, drv_on}, 9'd1, "R2 held high no fall");
      samp = 1'b0;
      @(negedge clk);
      m_en = en_in;
      m_over = over_of(en_in);
      check({6'd0, drv_on}, {6'd0, exp_on()}, "R2 fall latches");

      // R5: independence, one at a time at max code
      wr(3'b111, 3'd7, 3'd7, 3'd7);
      for (int i = 0; i < 3; i++) begin
         en_in = 3'(1 << i);
         pulse();
         check({6'd0, drv_on}, {6'd0, 3'(1 << i)}, "R5 single channel");
      end

      // R4: exactly 12 units drives
      wr(3'b111, 3'd3, 3'd3, 3'd3);
      en_in = 3'b111;
      pulse();
      check({6'd0, drv_on}, 9'b111, "R4 sum equals budget");

      // R7: raise a code between pulses, no change until next fall
      wr(3'b100, 3'd0, 3'd0, 3'd4);
      repeat (3) @(negedge clk);
      check({6'd0, drv_on}, 9'b111, "R7 write between pulses");
      pulse();
      check({6'd0, drv_on}, 9'd0, "R3 sum 13 blocks all");

      // R3: two channels over budget, then dropping one restores
      wr(3'b111, 3'd6, 3'd5, 3'd0);
      en_in = 3'b011;
      pulse();
      check({6'd0, drv_on}, 9'd0, "R3 two channels 13 units");
      en_in = 3'b001;
      pulse();
      check({6'd0, drv_on}, 9'b001, "R3 single under budget");

      // R6: power down and restore
      en_in = 3'b101;
      pulse();
      @(negedge clk);
      pwr_on = 1'b0;
      #1;
      check({6'd0, drv_on}, 9'd0, "R6 power down same cycle");
      @(negedge clk);
      pwr_on = 1'b1;
      #1;
      check({6'd0, drv_on}, {6'd0, exp_on()}, "R6 restore");

      // random mix
      for (int k = 0; k < 300; k++) begin
         if ($urandom_range(0, 2) == 0)
            wr(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
         @(negedge clk);
         en_in = 3'($urandom_range(0, 7));
         pwr_on = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 3) != 0) pulse();
         else repeat (2) @(negedge clk);
         check({6'd0, drv_on}, {6'd0, exp_on()}, "R3 R5 random drv_on");
         check(drv_lvl, exp_lvl(), "R1 random codes");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule